// File: doc/BRIEF.md
# Four-Plane Tile Raster Writer

This block sits between a CPU write path and a bit-planar graphics store organised as four colour planes (plane 0 blue, plane 1 red, plane 2 green, plane 3 extra) in each of two banks. It does not store the CPU byte. It turns each CPU byte or word write into one plane operation per clock. In tile mode every enabled plane byte takes that plane's 8-bit tile value. In merge mode the CPU data acts as a bit mask: masked bits come from the tile value and unmasked bits keep the old plane contents. The plane store is 16 bits wide, with two byte lanes and an asynchronous read port. A word at an odd byte address is therefore split into two single-lane accesses per plane.

Before it touches the planes, the unit sends one OR-strobe per written byte position to an external update-flag store, and it sets the bank's bit in a graphics-dirty register. The display side clears that register with a pulse. A programmable wait then stalls the requester, and a one-cycle `done` ends the operation. The request, plane-disable mask, tile values and wait length are all captured when the write is accepted.

Top module: `tdw_tile_writer`

## Requirements
- R1: `plane_dis` is active low per plane (bit p = 1 means plane p is skipped): a disabled plane gets no `mem_we` cycle, but it still takes its clock slot.
- R2: With `op_rmw`=0 (tile mode), each enabled plane byte receives bits [8p+7:8p] of `tile_bytes`, whatever `wr_data` holds.
- R3: With `op_rmw`=1 (merge mode), each enabled plane byte becomes (old AND NOT mask) OR (tile AND mask). The mask is `wr_data[7:0]` for the byte at `wr_addr` and `wr_data[15:8]` for the byte at `wr_addr`+1.
- R4: A merge-mode write whose data is all ones (0xFF in `wr_data[7:0]` for a byte write, 0xFFFF for a word write) behaves exactly as a tile-mode write. A word value of 0x00FF is not all ones and merges with a zero high mask.
- R5: A merge-mode write with zero data (`wr_data[7:0]`=0 for a byte, `wr_data`=0 for a word) makes no plane writes and no update strobes, and leaves `gfx_dirty` alone. It still raises `done` exactly `wait_len` cycles after acceptance.
- R6: A word write at an even address makes one access per plane at word index `wr_addr[ADDR_W-1:1]` with `mem_be`=11. Lane 0 (`mem_wdata[7:0]`) is the byte at `wr_addr`, and lane 1 is the byte at `wr_addr`+1.
- R7: A word write at an odd address makes two single-lane accesses per plane, all planes for `wr_addr` first (lane 1, `mem_be`=10) and then all planes for `wr_addr`+1 (lane 0, `mem_be`=01), with the address wrapping modulo 2^ADDR_W. A byte write uses lane `wr_addr[0]` only.
- R8: Update strobes come before any plane access, one per byte position: `upd_addr` = `wr_addr`, then `wr_addr`+1 (for words, modulo 2^ADDR_W). `upd_bits` is 01 for bank 0 and 10 for bank 1.
- R9: `gfx_dirty[bank]` is set at the end of the first update strobe. `dirty_clr` clears the bits it names at the next edge, and a set in the same cycle wins over a clear of the same bit.
- R10: Operations run plane 0 to plane 3. Counting the first cycle after acceptance as 0, `done` is high for one cycle at cycle (byte positions + 4 × accesses per plane + `wait_len`). `wr_ready` is low from acceptance until after `done`.
- R11: Changes to `plane_dis`, `tile_bytes`, `op_rmw` or `wait_len` after acceptance do not affect the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU write request |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_bank | input | 1 | Target bank |
| wr_addr | input | ADDR_W | Byte address within a plane |
| wr_data | input | 16 | CPU write data / merge mask |
| wr_ready | output | 1 | Unit idle, request accepted this cycle |
| op_rmw | input | 1 | 1 = merge mode, 0 = tile mode |
| plane_dis | input | PLANES | Active-low plane enables |
| tile_bytes | input | PLANES*8 | Tile value per plane, plane p at bits 8p+7:8p |
| wait_len | input | WAIT_W | Stall cycles after the plane phase |
| dirty_clr | input | 2 | Clear pulse for graphics-dirty bits |
| mem_we | output | 1 | Plane store write strobe |
| mem_plane | output | PL_W | Plane index of the access |
| mem_bank | output | 1 | Bank of the access |
| mem_addr | output | ADDR_W-1 | Word index in the plane store |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Merged write data |
| mem_rdata | input | 16 | Current contents of the addressed word (same cycle) |
| upd_we | output | 1 | Update-flag OR strobe |
| upd_addr | output | ADDR_W | Byte position being marked |
| upd_bits | output | 2 | Bits to OR into the flag |
| gfx_dirty | output | 2 | Graphics-dirty register, one bit per bank |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The display-side clear of `gfx_dirty` and the bank set from an update strobe can fall on the same edge. The bench provokes this by driving `dirty_clr`=11 during cycle 0 after accepting a bank-1 write, while bit 0 is already set from an earlier write. Once `done` has passed, `gfx_dirty` must read exactly 10: the new set survives and the older bit is cleared. A second overlap changes every captured input in that same first cycle and checks that the plane data and the latency still follow the accepted values.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_MARK,
      S_PLANE,
      S_WAIT,
      S_DONE
   } seq_state_e;

   localparam int LANES  = 2;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/tdw_mode_decode.sv
module tdw_mode_decode (
   input  logic        word,
   input  logic        rmw,
   input  logic [15:0] data,
   output logic [7:0]  mask_lo,
   output logic [7:0]  mask_hi,
   output logic        null_op
);
   logic all_ones;
   logic all_zero;
   logic tile_eff;

   always_comb begin
      all_ones = word ? (data == 16'hFFFF) : (data[7:0] == 8'hFF);
      all_zero = word ? (data == 16'h0000) : (data[7:0] == 8'h00);
      // full mask in merge mode degenerates to a plain tile write
      tile_eff = !rmw || all_ones;
      mask_lo  = tile_eff ? 8'hFF : data[7:0];
      mask_hi  = tile_eff ? 8'hFF : data[15:8];
      null_op  = rmw && all_zero;
   end
endmodule

// File: rtl/tdw_lane_merge.sv
module tdw_lane_merge #(
   parameter int LANES = 2
) (
   input  logic [LANES*8-1:0] old_word,
   input  logic [LANES*8-1:0] mask_word,
   input  logic [7:0]         tile,
   output logic [LANES*8-1:0] new_word
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign new_word[l*8 +: 8] = (old_word[l*8 +: 8] & ~mask_word[l*8 +: 8])
                                | (tile & mask_word[l*8 +: 8]);
   end
endmodule

// File: rtl/tdw_plane_seq.sv
module tdw_plane_seq
   import tdw_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int WAIT_W = 8,
   parameter int PL_W   = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              null_op,
   input  logic [WAIT_W-1:0] wait_len,
   input  logic              two_marks,
   input  logic              two_parts,
   output seq_state_e        state,
   output logic              mark_idx,
   output logic              part_idx,
   output logic [PL_W-1:0]   plane_idx
);
   localparam logic [PL_W-1:0] PL_LAST = PL_W'(PLANES - 1);

   logic [WAIT_W-1:0] wlen_q;
   logic [WAIT_W-1:0] wcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         mark_idx  <= 1'b0;
         part_idx  <= 1'b0;
         plane_idx <= '0;
         wlen_q    <= '0;
         wcnt_q    <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  wlen_q    <= wait_len;
                  mark_idx  <= 1'b0;
                  part_idx  <= 1'b0;
                  plane_idx <= '0;
                  if (!null_op) begin
                     state <= S_MARK;
                  end else if (wait_len == '0) begin
                     state <= S_DONE;
                  end else begin
                     state  <= S_WAIT;
                     wcnt_q <= wait_len;
                  end
               end
            end
            S_MARK: begin
               if (!two_marks || mark_idx) begin
                  state <= S_PLANE;
               end else begin
                  mark_idx <= 1'b1;
               end
            end
            S_PLANE: begin
               if (plane_idx == PL_LAST) begin
                  plane_idx <= '0;
                  if (!two_parts || part_idx) begin
                     if (wlen_q == '0) begin
                        state <= S_DONE;
                     end else begin
                        state  <= S_WAIT;
                        wcnt_q <= wlen_q;
                     end
                  end else begin
                     part_idx <= 1'b1;
                  end
               end else begin
                  plane_idx <= plane_idx + 1'b1;
               end
            end
            S_WAIT: begin
               if (wcnt_q == WAIT_W'(1)) begin
                  state <= S_DONE;
               end else begin
                  wcnt_q <= wcnt_q - 1'b1;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tdw_tile_writer.sv
module tdw_tile_writer
   import tdw_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int PLANES = 4,
   parameter int WAIT_W = 8,
   parameter int PL_W   = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic                  wr_word,
   input  logic                  wr_bank,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [15:0]           wr_data,
   output logic                  wr_ready,
   input  logic                  op_rmw,
   input  logic [PLANES-1:0]     plane_dis,
   input  logic [PLANES*8-1:0]   tile_bytes,
   input  logic [WAIT_W-1:0]     wait_len,
   input  logic [1:0]            dirty_clr,
   output logic                  mem_we,
   output logic [PL_W-1:0]       mem_plane,
   output logic                  mem_bank,
   output logic [ADDR_W-2:0]     mem_addr,
   output logic [1:0]            mem_be,
   output logic [15:0]           mem_wdata,
   input  logic [15:0]           mem_rdata,
   output logic                  upd_we,
   output logic [ADDR_W-1:0]     upd_addr,
   output logic [1:0]            upd_bits,
   output logic [1:0]            gfx_dirty,
   output logic                  busy,
   output logic                  done
);
   localparam int DATA_W = LANES * BYTE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("tdw_tile_writer: ADDR_W must be at least 2");
   end
   if (PLANES < 1 || PLANES > 8) begin : g_bad_planes
      $error("tdw_tile_writer: PLANES must be 1..8");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("tdw_tile_writer: WAIT_W must be at least 1");
   end

   seq_state_e           state;
   logic                 mark_idx;
   logic                 part_idx;
   logic [PL_W-1:0]      plane_idx;

   logic                 accept;
   logic [7:0]           dec_mlo;
   logic [7:0]           dec_mhi;
   logic                 dec_null;

   logic                 bank_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [7:0]           mlo_q;
   logic [7:0]           mhi_q;
   logic                 word_q;
   logic                 odd_q;
   logic [PLANES-1:0]    dis_q;
   logic [PLANES*8-1:0]  tiles_q;
   logic [1:0]           dirty_q;

   logic [ADDR_W-1:0]    byte_a;
   logic [7:0]           mask_b;
   logic [DATA_W-1:0]    mask_w;
   logic [7:0]           tile_sel;
   logic [1:0]           bank_bit;
   logic [1:0]           dirty_set;

   assign wr_ready = (state == S_IDLE);
   assign accept   = wr_valid && wr_ready;

   tdw_mode_decode u_decode (
      .word    (wr_word),
      .rmw     (op_rmw),
      .data    (wr_data),
      .mask_lo (dec_mlo),
      .mask_hi (dec_mhi),
      .null_op (dec_null)
   );

   tdw_plane_seq #(
      .PLANES (PLANES),
      .WAIT_W (WAIT_W),
      .PL_W   (PL_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .null_op   (dec_null),
      .wait_len  (wait_len),
      .two_marks (word_q),
      .two_parts (odd_q),
      .state     (state),
      .mark_idx  (mark_idx),
      .part_idx  (part_idx),
      .plane_idx (plane_idx)
   );

   // capture of the request and of the mode/tile settings
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q  <= 1'b0;
         addr_q  <= '0;
         mlo_q   <= '0;
         mhi_q   <= '0;
         word_q  <= 1'b0;
         odd_q   <= 1'b0;
         dis_q   <= '0;
         tiles_q <= '0;
      end else if (accept) begin
         bank_q  <= wr_bank;
         addr_q  <= wr_addr;
         mlo_q   <= dec_mlo;
         mhi_q   <= wr_word ? dec_mhi : 8'h00;
         word_q  <= wr_word;
         odd_q   <= wr_word && wr_addr[0];
         dis_q   <= plane_dis;
         tiles_q <= tile_bytes;
      end
   end

   assign bank_bit = bank_q ? 2'b10 : 2'b01;

   // update-flag marking, one strobe per byte position
   assign upd_we   = (state == S_MARK);
   assign upd_addr = addr_q + ADDR_W'(mark_idx);
   assign upd_bits = bank_bit;

   // plane access addressing and lane selection
   always_comb begin
      byte_a = addr_q + ADDR_W'(part_idx);
      mask_b = part_idx ? mhi_q : mlo_q;
      if (word_q && !odd_q) begin
         mem_be = 2'b11;
         mask_w = {mhi_q, mlo_q};
      end else if (byte_a[0]) begin
         mem_be = 2'b10;
         mask_w = {mask_b, 8'h00};
      end else begin
         mem_be = 2'b01;
         mask_w = {8'h00, mask_b};
      end
      tile_sel = tiles_q[{plane_idx, 3'b000} +: 8];
   end

   assign mem_addr  = byte_a[ADDR_W-1:1];
   assign mem_plane = plane_idx;
   assign mem_bank  = bank_q;
   assign mem_we    = (state == S_PLANE) && !dis_q[plane_idx];

   tdw_lane_merge #(
      .LANES (LANES)
   ) u_merge (
      .old_word  (mem_rdata),
      .mask_word (mask_w),
      .tile      (tile_sel),
      .new_word  (mem_wdata)
   );

   // graphics-dirty register: set has priority over clear
   assign dirty_set = (state == S_MARK && !mark_idx) ? bank_bit : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dirty_q <= 2'b00;
      end else begin
         dirty_q <= (dirty_q & ~dirty_clr) | dirty_set;
      end
   end

   assign gfx_dirty = dirty_q;
   assign busy      = (state != S_IDLE);
   assign done      = (state == S_DONE);
endmodule

// File: rtl/tdw_tile_writer_chk.sv
module tdw_tile_writer_chk #(
   parameter int PLANES = 4,
   parameter int PL_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [PLANES-1:0] plane_dis,
   input logic              mem_we,
   input logic [PL_W-1:0]   mem_plane,
   input logic [1:0]        mem_be,
   input logic              upd_we,
   input logic [1:0]        upd_bits,
   input logic [1:0]        gfx_dirty,
   input logic              busy,
   input logic              done
);
   logic [PLANES-1:0] dis_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dis_cap <= '0;
      end else if (wr_valid && wr_ready) begin
         dis_cap <= plane_dis;
      end
   end

   assert_disabled_plane_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !dis_cap[mem_plane]);

   assert_lane_enable_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_be != 2'b00));

   assert_single_bank_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |-> ($countones(upd_bits) == 1));

   assert_dirty0_from_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gfx_dirty[0]) |-> $past(upd_we && upd_bits[0]));

   assert_dirty1_from_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gfx_dirty[1]) |-> $past(upd_we && upd_bits[1]));

   assert_mark_plane_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && upd_we));

   assert_accept_goes_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> busy);

   assert_done_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind tdw_tile_writer tdw_tile_writer_chk #(
   .PLANES (PLANES),
   .PL_W   (PL_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .plane_dis (plane_dis),
   .mem_we    (mem_we),
   .mem_plane (mem_plane),
   .mem_be    (mem_be),
   .upd_we    (upd_we),
   .upd_bits  (upd_bits),
   .gfx_dirty (gfx_dirty),
   .busy      (busy),
   .done      (done)
);

// File: tb/tdw_tile_writer_tb_top.sv
module tdw_tile_writer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int NP = 4;
   localparam int WW = 8;

   localparam logic [1:0] K_UPD  = 2'd0;
   localparam logic [1:0] K_MEM  = 2'd1;
   localparam logic [1:0] K_DONE = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic [15:0] a;
      logic [7:0]  b;
      logic [1:0]  be;
      logic [15:0] d;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic          wr_word = 1'b0;
   logic          wr_bank = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic          wr_ready;
   logic          op_rmw = 1'b0;
   logic [NP-1:0] plane_dis = '0;
   logic [NP*8-1:0] tile_bytes = '0;
   logic [WW-1:0] wait_len = '0;
   logic [1:0]    dirty_clr = 2'b00;
   logic          mem_we;
   logic [1:0]    mem_plane;
   logic          mem_bank;
   logic [AW-2:0] mem_addr;
   logic [1:0]    mem_be;
   logic [15:0]   mem_wdata;
   logic [15:0]   mem_rdata;
   logic          upd_we;
   logic [AW-1:0] upd_addr;
   logic [1:0]    upd_bits;
   logic [1:0]    gfx_dirty;
   logic          busy;
   logic          done;

   item_t exp_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   int    t0 = 0;
   bit    finished = 1'b0;
   logic [1:0] exp_dirty = 2'b00;
   logic [7:0]  rmem [0:1][0:3][0:255];
   logic [15:0] bmem [0:1][0:3][0:127];

   always #(CLK_PERIOD/2) clk = ~clk;

   tdw_tile_writer #(.ADDR_W(AW), .PLANES(NP), .WAIT_W(WW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
      .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .op_rmw(op_rmw), .plane_dis(plane_dis), .tile_bytes(tile_bytes),
      .wait_len(wait_len), .dirty_clr(dirty_clr), .mem_we(mem_we),
      .mem_plane(mem_plane), .mem_bank(mem_bank), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .upd_we(upd_we), .upd_addr(upd_addr), .upd_bits(upd_bits),
      .gfx_dirty(gfx_dirty), .busy(busy), .done(done)
   );

   function automatic logic [7:0] pat(int b, int p, int a);
      return 8'(a * 7 + p * 29 + b * 101 + 3);
   endfunction

   function automatic logic [7:0] mrg(logic [7:0] old, logic [7:0] t, logic [7:0] m);
      return (old & ~m) | (t & m);
   endfunction

   // plane store model: asynchronous read, lane-enabled write
   assign mem_rdata = bmem[mem_bank][mem_plane][mem_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int p = 0; p < 4; p++)
               for (int w = 0; w < 128; w++)
                  bmem[b][p][w] <= {pat(b, p, 2*w+1), pat(b, p, 2*w)};
      end else if (mem_we) begin
         if (mem_be[0]) bmem[mem_bank][mem_plane][mem_addr][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) bmem[mem_bank][mem_plane][mem_addr][15:8] <= mem_wdata[15:8];
      end
   end

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      item_t it;
      logic [15:0] bm;
      cyc = cyc + 1;
      if (rst_n) begin
         if (upd_we) begin
            it = (exp_q.size() != 0) ? exp_q[0] : '0;
            n_chk++;
            if (exp_q.size() == 0 || it.kind != K_UPD || it.a != 16'(upd_addr) ||
                it.b != 8'(upd_bits)) begin
               n_bad++;
               $display("FAIL R8 update strobe: got addr=%0h bits=%0b, expected kind=%0d addr=%0h bits=%0b",
                        upd_addr, upd_bits, it.kind, it.a, it.b);
            end
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
         if (mem_we) begin
            it = (exp_q.size() != 0) ? exp_q[0] : '0;
            bm = {{8{mem_be[1]}}, {8{mem_be[0]}}};
            n_chk++;
            if (exp_q.size() == 0 || it.kind != K_MEM || it.a != 16'({mem_bank, mem_addr}) ||
                it.b != 8'(mem_plane) || it.be != mem_be || (mem_wdata & bm) != (it.d & bm)) begin
               n_bad++;
               $display("FAIL R3 plane write: got bank/addr=%0h plane=%0d be=%0b data=%h, expected kind=%0d bank/addr=%0h plane=%0d be=%0b data=%h",
                        {mem_bank, mem_addr}, mem_plane, mem_be, mem_wdata,
                        it.kind, it.a, it.b, it.be, it.d);
            end
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
         if (done) begin
            it = (exp_q.size() != 0) ? exp_q[0] : '0;
            n_chk++;
            if (exp_q.size() == 0 || it.kind != K_DONE || it.a != 16'(cyc - t0)) begin
               n_bad++;
               $display("FAIL R10 done latency: got %0d, expected kind=%0d latency=%0d",
                        cyc - t0, it.kind, it.a);
            end
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   // driver: computes expected items, pushes them, then issues the write
   task automatic run_op(input bit word, input bit bank, input logic [7:0] addr,
                         input logic [15:0] data, input bit rmw, input logic [3:0] dis,
                         input logic [31:0] tiles, input logic [7:0] wl,
                         input bit clr0, input bit scr);
      bit full, zero, tdw, nul;
      logic [7:0] ml, mh, a, lo, hi, nb;
      int nbytes, nparts;
      item_t it;
      full = word ? (data == 16'hFFFF) : (data[7:0] == 8'hFF);
      zero = word ? (data == 16'h0000) : (data[7:0] == 8'h00);
      tdw  = !rmw || full;
      nul  = rmw && zero;
      ml   = tdw ? 8'hFF : data[7:0];
      mh   = tdw ? 8'hFF : data[15:8];
      nbytes = word ? 2 : 1;
      nparts = (word && addr[0]) ? 2 : 1;
      if (!nul) begin
         for (int k = 0; k < nbytes; k++) begin
            it = '0; it.kind = K_UPD; it.a = 16'(8'(addr + 8'(k)));
            it.b = bank ? 8'd2 : 8'd1;
            exp_q.push_back(it);
         end
         if (word && !addr[0]) begin
            for (int p = 0; p < 4; p++) begin
               if (!dis[p]) begin
                  lo = mrg(rmem[bank][p][addr], tiles[p*8 +: 8], ml);
                  hi = mrg(rmem[bank][p][8'(addr + 8'd1)], tiles[p*8 +: 8], mh);
                  rmem[bank][p][addr] = lo;
                  rmem[bank][p][8'(addr + 8'd1)] = hi;
                  it = '0; it.kind = K_MEM; it.a = 16'({bank, addr[7:1]});
                  it.b = 8'(p); it.be = 2'b11; it.d = {hi, lo};
                  exp_q.push_back(it);
               end
            end
         end else begin
            for (int j = 0; j < nparts; j++) begin
               a = 8'(addr + 8'(j));
               for (int p = 0; p < 4; p++) begin
                  if (!dis[p]) begin
                     nb = mrg(rmem[bank][p][a], tiles[p*8 +: 8], (j == 1) ? mh : ml);
                     rmem[bank][p][a] = nb;
                     it = '0; it.kind = K_MEM; it.a = 16'({bank, a[7:1]});
                     it.b = 8'(p); it.be = a[0] ? 2'b10 : 2'b01;
                     it.d = a[0] ? {nb, 8'h00} : {8'h00, nb};
                     exp_q.push_back(it);
                  end
               end
            end
         end
      end
      it = '0; it.kind = K_DONE;
      it.a = nul ? 16'(wl) : 16'(nbytes + 4 * nparts + int'(wl));
      exp_q.push_back(it);
      if (clr0) exp_dirty = 2'b00;
      if (!nul) exp_dirty = exp_dirty | (bank ? 2'b10 : 2'b01);

      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_word = word; wr_bank = bank; wr_addr = addr;
      wr_data = data; op_rmw = rmw; plane_dis = dis; tile_bytes = tiles; wait_len = wl;
      @(posedge clk);
      t0 = cyc + 1;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (i == 0) begin
            wr_valid = 1'b0;
            check(!wr_ready, "R10 ready low after accept", wr_ready, 0);
            if (clr0) dirty_clr = 2'b11;
            if (scr) begin
               plane_dis = 4'hF; tile_bytes = 32'h0; wait_len = 8'd200; op_rmw = ~rmw;
            end
         end
         if (i == 1) dirty_clr = 2'b00;
         if (done) break;
      end
      dirty_clr = 2'b00;
      @(negedge clk);
      check(gfx_dirty == exp_dirty, "R9 graphics-dirty after op", gfx_dirty, exp_dirty);
   endtask

   initial begin
      for (int b = 0; b < 2; b++)
         for (int p = 0; p < 4; p++)
            for (int x = 0; x < 256; x++)
               rmem[b][p][x] = pat(b, p, x);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_ready && !busy && !done, "R10 reset idle", {wr_ready, busy, done}, 3'b100);
      check(gfx_dirty == 2'b00, "R9 reset dirty", gfx_dirty, 0);
      check(!mem_we && !upd_we, "R8 reset strobes", {mem_we, upd_we}, 0);

      // R2: tile mode byte, even address, all planes
      run_op(1'b0, 1'b0, 8'h10, 16'h005A, 1'b0, 4'b0000, 32'hA53CF00F, 8'd3, 1'b0, 1'b0);
      // R1 R2: tile mode byte, odd address, planes 0 and 2 disabled
      run_op(1'b0, 1'b1, 8'h21, 16'h0011, 1'b0, 4'b0101, 32'h5566AA99, 8'd2, 1'b0, 1'b0);
      // R3: merge on previously tiled bytes
      run_op(1'b0, 1'b0, 8'h10, 16'h003C, 1'b1, 4'b0000, 32'h12345678, 8'd1, 1'b0, 1'b0);
      // R4: merge byte 0xFF acts as tile write
      run_op(1'b0, 1'b1, 8'h33, 16'h00FF, 1'b1, 4'b0000, 32'hDEADBEEF, 8'd0, 1'b0, 1'b0);

      // R9: idle clear
      @(negedge clk); dirty_clr = 2'b11;
      @(negedge clk); dirty_clr = 2'b00;
      @(negedge clk);
      exp_dirty = 2'b00;
      check(gfx_dirty == 2'b00, "R9 idle clear", gfx_dirty, 0);

      // R5: merge with zero low byte, only wait cycles
      run_op(1'b0, 1'b0, 8'h40, 16'hFF00, 1'b1, 4'b0000, 32'hFFFFFFFF, 8'd5, 1'b0, 1'b0);
      // R6: even word merge, plane 1 disabled
      run_op(1'b1, 1'b1, 8'h50, 16'h0FF0, 1'b1, 4'b0010, 32'hC3A5967E, 8'd2, 1'b0, 1'b0);
      // R4: word 0xFFFF acts as tile write
      run_op(1'b1, 1'b0, 8'h62, 16'hFFFF, 1'b1, 4'b0000, 32'h01020304, 8'd1, 1'b0, 1'b0);
      // R7 R4: odd word merge 0x00FF (not all ones), plane 3 disabled
      run_op(1'b1, 1'b1, 8'h71, 16'h00FF, 1'b1, 4'b1000, 32'h8899AABB, 8'd0, 1'b0, 1'b0);
      // R7 R8: odd word at top address wraps to 0
      run_op(1'b1, 1'b0, 8'hFF, 16'h1234, 1'b0, 4'b0000, 32'h0F1E2D3C, 8'd2, 1'b0, 1'b0);
      // R9: clear and set on the same edge
      run_op(1'b0, 1'b1, 8'h05, 16'h0000, 1'b0, 4'b0000, 32'h44332211, 8'd1, 1'b1, 1'b0);
      // R11: inputs changed right after acceptance
      run_op(1'b0, 1'b0, 8'h90, 16'h000F, 1'b1, 4'b0000, 32'h9A8B7C6D, 8'd4, 1'b0, 1'b1);
      // R5: null word merge with no wait
      run_op(1'b1, 1'b1, 8'h10, 16'h0000, 1'b1, 4'b0000, 32'h11111111, 8'd0, 1'b0, 1'b0);
      // R1: every plane disabled, marks only
      run_op(1'b1, 1'b0, 8'hA4, 16'h5555, 1'b0, 4'b1111, 32'h77777777, 8'd1, 1'b0, 1'b0);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 all expected events seen", exp_q.size(), 0);
      begin
         int mism;
         mism = 0;
         for (int b = 0; b < 2; b++)
            for (int p = 0; p < 4; p++)
               for (int w = 0; w < 128; w++)
                  if (bmem[b][p][w] != {rmem[b][p][2*w+1], rmem[b][p][2*w]}) mism++;
         check(mism == 0, "R3 final plane contents mismatching words", mism, 0);
      end
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule